// File: doc/BRIEF.md
# USB Device Controller Register Front End

This block sits between a processor's memory-mapped bus and the packet engine of a small USB device controller that has three endpoints: endpoint 0 for control traffic, endpoint 1 for bulk OUT (host to device) and endpoint 2 for bulk IN (device to host). Software uses it to program the controller, to read and clear the event flags that drive one interrupt line, and to move payload bytes. The packet engine uses a set of valid/ready byte streams to fill and drain the same FIFOs.

Endpoint 0 has one 8-byte FIFO that carries data in both directions. A byte counter tracks how many bytes the engine has delivered into it. The two bulk endpoints share a single bus address: a read takes the oldest byte from the OUT FIFO, and a write appends a byte to the IN FIFO. Every bus write passes through a one-deep synchronizing stage before it takes effect. Software therefore sees the old contents on a read issued the cycle after a write, and must not issue writes back to back.

Bus reads are combinational: `bus_rdata` is valid in the cycle `bus_rd` is high, and a read that pops a FIFO removes the byte at the following clock edge. All core-side streams follow valid/ready rules. A byte moves on a clock edge where both valid and ready are high. A source keeps valid and data steady until the byte is accepted. `ep0_rx_ready` and `out_rx_ready` drop when their FIFO is full. `ep0_rx_ready` also drops in the cycle a software byte is being written into the endpoint 0 FIFO. `ep0_tx_valid` drops in any cycle where software reads the endpoint 0 data address. While the controller is disabled, every core-side valid and ready is low.

Top module: `usbdev_regif`

Register addresses on `bus_addr`: 0 control, 1 event flags, 2 device address, 3 OUT max packet, 4 IN max packet, 5/6/7 endpoint 0/1/2 control-status, 8 endpoint 0 data, 9 endpoint 0 receive count, 10 bulk data. Unmapped addresses read as 0.

## Requirements
- R1: After reset the control register reads 0x7D: bit 0 (disable) is 1, bit 1 (wake enable) is 0, and mask bits [6:2] are all 1. Software must still program the masks before it enables the controller. All other registers read 0, and `irq` and `wr_busy` are low.
- R2: A write issued in cycle n takes effect at the edge that ends cycle n+1. A read in cycle n+1 returns the old value, and a read in cycle n+2 returns the new value.
- R3: `wr_busy` is high in the cycle after an accepted write. A write issued while `wr_busy` is high is dropped and has no effect on any register or FIFO.
- R4: The device address register keeps only bits [6:0] of the written byte, reads back with bit 7 as 0, and drives `dev_addr`.
- R5: The event flags are bit 0 for an endpoint 0 core push, bit 1 for an OUT core push, bit 2 for an IN core pop, bit 3 for underrun and bit 4 for overrun. A flag is set by its event. It is cleared by writing 1 to it and is left unchanged by writing 0. If a set and a clear fall in the same cycle, the set wins.
- R6: `irq` is high exactly when the controller is enabled (control bit 0 = 0) and some event flag i is set while control bit 2+i is 0.
- R7: The endpoint 0 FIFO holds 8 bytes in first-in first-out order. Core-side pushes and software writes to address 8 both add bytes. Core-side pops and software reads from address 8 both remove bytes.
- R8: The endpoint 0 count increases by one on each accepted core-side endpoint 0 push. It is cleared when a software read takes the last byte out of the FIFO, or when software writes the endpoint 0 control-status register. A core push in the same cycle still counts.
- R9: A read at address 10 returns and removes the oldest OUT byte. A write at address 10 appends a byte to the IN FIFO. Both bulk FIFOs are 8 deep.
- R10: A software read of an empty endpoint 0 or OUT FIFO returns 0, removes nothing and sets event flag 3.
- R11: A software write to a full endpoint 0 or IN FIFO discards the byte, leaves the FIFO unchanged and sets event flag 4.
- R12: The core-side streams follow the back-pressure rules above, and all of them are held off while the controller is disabled.
- R13: The two max packet registers and the three control-status registers store all 8 written bits and read them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; pops FIFO data addresses |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| wr_busy | output | 1 | A write is in the synchronizer |
| irq | output | 1 | Unmasked event interrupt |
| dev_addr | output | 7 | Assigned USB device address |
| ep0_rx_valid | input | 1 | Core offers a received endpoint 0 byte |
| ep0_rx_data | input | 8 | Received endpoint 0 byte |
| ep0_rx_ready | output | 1 | Endpoint 0 FIFO accepts the byte |
| ep0_tx_valid | output | 1 | Endpoint 0 byte available to send |
| ep0_tx_data | output | 8 | Endpoint 0 byte to send |
| ep0_tx_ready | input | 1 | Core takes the endpoint 0 byte |
| out_rx_valid | input | 1 | Core offers a bulk OUT byte |
| out_rx_data | input | 8 | Bulk OUT byte |
| out_rx_ready | output | 1 | OUT FIFO accepts the byte |
| in_tx_valid | output | 1 | Bulk IN byte available |
| in_tx_data | output | 8 | Bulk IN byte |
| in_tx_ready | input | 1 | Core takes the bulk IN byte |

## Verification
The hardest case to reach is contention on the shared endpoint 0 FIFO: a synchronized software write landing while the core holds a push pending, and a software read in the same cycle the core is ready to take a byte. The stimulus keeps `ep0_rx_valid` and `ep0_tx_ready` high continuously while it issues a write and then back-to-back reads at address 8. The reference model must then reproduce which side is held off in each cycle. Overrun and the drain-to-empty count clear are reached by filling the FIFO with nine software writes and emptying it with nine reads.

// File: rtl/usbdev_regif_pkg.sv
package usbdev_regif_pkg;
  localparam int BW = 8;     // bus data width (byte port)
  localparam int NEV = 5;    // number of event flags

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_EVT   = 4'd1;
  localparam logic [3:0] A_DADDR = 4'd2;
  localparam logic [3:0] A_OMPS  = 4'd3;
  localparam logic [3:0] A_IMPS  = 4'd4;
  localparam logic [3:0] A_CSR0  = 4'd5;
  localparam logic [3:0] A_EP0D  = 4'd8;
  localparam logic [3:0] A_E0CNT = 4'd9;
  localparam logic [3:0] A_BULK  = 4'd10;

  localparam int EV_E0RX  = 0;
  localparam int EV_OUTRX = 1;
  localparam int EV_INTX  = 2;
  localparam int EV_UNDER = 3;
  localparam int EV_OVER  = 4;

  localparam logic [6:0] CTRL_RST = 7'h7D;
endpackage

// File: rtl/usbdev_fifo.sv
module usbdev_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8   // power of two
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              head,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (pop)  rp <= rp + PW'(1);
      cnt <= cnt + {{PW{1'b0}}, push} - {{PW{1'b0}}, pop};
    end
  end

  assign head  = mem[rp];
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign count = cnt;

  a_r11_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r10_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (PW+1)'(DEPTH));
endmodule

// File: rtl/usbdev_wr_sync.sv
module usbdev_wr_sync #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          apply,
  output logic [AW-1:0] ap_addr,
  output logic [DW-1:0] ap_data
);
  logic          vld;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      a_q <= '0;
      d_q <= '0;
    end else if (wr && !vld) begin
      vld <= 1'b1;
      a_q <= addr;
      d_q <= wdata;
    end else begin
      vld <= 1'b0;
    end
  end

  assign busy    = vld;
  assign apply   = vld;
  assign ap_addr = a_q;
  assign ap_data = d_q;

  a_r3_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && busy) |=> !apply);
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !busy) |=> (apply && ap_addr == $past(addr) && ap_data == $past(wdata)));
endmodule

// File: rtl/usbdev_regif.sv
module usbdev_regif
  import usbdev_regif_pkg::*;
#(
  parameter int EP0_DEPTH  = 8,
  parameter int BULK_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  output logic       wr_busy,
  output logic       irq,
  output logic [6:0] dev_addr,
  input  logic       ep0_rx_valid,
  input  logic [7:0] ep0_rx_data,
  output logic       ep0_rx_ready,
  output logic       ep0_tx_valid,
  output logic [7:0] ep0_tx_data,
  input  logic       ep0_tx_ready,
  input  logic       out_rx_valid,
  input  logic [7:0] out_rx_data,
  output logic       out_rx_ready,
  output logic       in_tx_valid,
  output logic [7:0] in_tx_data,
  input  logic       in_tx_ready
);
  localparam int E0CW = $clog2(EP0_DEPTH) + 1;
  localparam int BKCW = $clog2(BULK_DEPTH) + 1;
  localparam int NCSR = 3;

  // write synchronizer
  logic          ap_wr;
  logic [3:0]    ap_addr;
  logic [BW-1:0] ap_data;

  usbdev_wr_sync #(.AW(4), .DW(BW)) u_sync (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .busy(wr_busy), .apply(ap_wr), .ap_addr(ap_addr), .ap_data(ap_data));

  // registers
  logic [6:0]     ctrl_q, daddr_q;
  logic [NEV-1:0] evt_q, ev_set, ev_clr;
  logic [7:0]     omps_q, imps_q, cnt0_q;
  logic [7:0]     csr_rd [NCSR];
  logic           dev_off;
  logic [NEV-1:0] mask;

  assign dev_off = ctrl_q[0];
  assign mask    = ctrl_q[6:2];

  // endpoint 0 FIFO
  logic            e0_full, e0_empty, e0_push, e0_pop;
  logic            e0_core_push, e0_bus_wr, e0_bus_push, e0_rd;
  logic [7:0]      e0_head, e0_wdata;
  logic [E0CW-1:0] e0_cnt;

  assign e0_bus_wr    = ap_wr && ap_addr == A_EP0D;
  assign e0_rd        = bus_rd && bus_addr == A_EP0D;
  assign ep0_rx_ready = !dev_off && !e0_full && !e0_bus_wr;
  assign e0_core_push = ep0_rx_valid && ep0_rx_ready;
  assign e0_bus_push  = e0_bus_wr && !e0_full;
  assign e0_push      = e0_core_push || e0_bus_push;
  assign e0_wdata     = e0_core_push ? ep0_rx_data : ap_data;
  assign ep0_tx_valid = !dev_off && !e0_empty && !e0_rd;
  assign ep0_tx_data  = e0_head;
  assign e0_pop       = (ep0_tx_valid && ep0_tx_ready) || (e0_rd && !e0_empty);

  usbdev_fifo #(.DW(BW), .DEPTH(EP0_DEPTH)) u_ep0 (
    .clk(clk), .rst_n(rst_n), .push(e0_push), .wdata(e0_wdata), .pop(e0_pop),
    .head(e0_head), .full(e0_full), .empty(e0_empty), .count(e0_cnt));

  // bulk OUT FIFO: core pushes, software pops
  logic            o_full, o_empty, o_push, o_pop, bk_rd;
  logic [7:0]      o_head;
  logic [BKCW-1:0] o_cnt;

  assign bk_rd        = bus_rd && bus_addr == A_BULK;
  assign out_rx_ready = !dev_off && !o_full;
  assign o_push       = out_rx_valid && out_rx_ready;
  assign o_pop        = bk_rd && !o_empty;

  usbdev_fifo #(.DW(BW), .DEPTH(BULK_DEPTH)) u_out (
    .clk(clk), .rst_n(rst_n), .push(o_push), .wdata(out_rx_data), .pop(o_pop),
    .head(o_head), .full(o_full), .empty(o_empty), .count(o_cnt));

  // bulk IN FIFO: software pushes, core pops
  logic            i_full, i_empty, i_push, i_pop, bk_wr;
  logic [BKCW-1:0] i_cnt;

  assign bk_wr       = ap_wr && ap_addr == A_BULK;
  assign i_push      = bk_wr && !i_full;
  assign in_tx_valid = !dev_off && !i_empty;
  assign i_pop       = in_tx_valid && in_tx_ready;

  usbdev_fifo #(.DW(BW), .DEPTH(BULK_DEPTH)) u_in (
    .clk(clk), .rst_n(rst_n), .push(i_push), .wdata(ap_data), .pop(i_pop),
    .head(in_tx_data), .full(i_full), .empty(i_empty), .count(i_cnt));

  // event flags
  always_comb begin
    ev_set           = '0;
    ev_set[EV_E0RX]  = e0_core_push;
    ev_set[EV_OUTRX] = o_push;
    ev_set[EV_INTX]  = i_pop;
    ev_set[EV_UNDER] = (e0_rd && e0_empty) || (bk_rd && o_empty);
    ev_set[EV_OVER]  = (e0_bus_wr && e0_full) || (bk_wr && i_full);
    ev_clr           = (ap_wr && ap_addr == A_EVT) ? ap_data[NEV-1:0] : '0;
  end

  logic cnt_clr;
  assign cnt_clr = (e0_rd && e0_cnt == E0CW'(1)) || (ap_wr && ap_addr == A_CSR0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      daddr_q <= '0;
      omps_q  <= '0;
      imps_q  <= '0;
      evt_q   <= '0;
      cnt0_q  <= '0;
    end else begin
      if (ap_wr && ap_addr == A_CTRL)  ctrl_q  <= ap_data[6:0];
      if (ap_wr && ap_addr == A_DADDR) daddr_q <= ap_data[6:0];
      if (ap_wr && ap_addr == A_OMPS)  omps_q  <= ap_data;
      if (ap_wr && ap_addr == A_IMPS)  imps_q  <= ap_data;
      evt_q  <= (evt_q & ~ev_clr) | ev_set;
      cnt0_q <= (cnt_clr ? 8'd0 : cnt0_q) + {7'd0, e0_core_push};
    end
  end

  for (genvar g = 0; g < NCSR; g++) begin : g_csr
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (ap_wr && ap_addr == A_CSR0 + 4'(g)) q <= ap_data;
    end
    assign csr_rd[g] = q;
  end

  assign irq      = !dev_off && |(evt_q & ~mask);
  assign dev_addr = daddr_q;

  always_comb begin
    case (bus_addr)
      A_CTRL:      bus_rdata = {1'b0, ctrl_q};
      A_EVT:       bus_rdata = {{(BW-NEV){1'b0}}, evt_q};
      A_DADDR:     bus_rdata = {1'b0, daddr_q};
      A_OMPS:      bus_rdata = omps_q;
      A_IMPS:      bus_rdata = imps_q;
      A_CSR0:      bus_rdata = csr_rd[0];
      A_CSR0 + 1:  bus_rdata = csr_rd[1];
      A_CSR0 + 2:  bus_rdata = csr_rd[2];
      A_EP0D:      bus_rdata = e0_empty ? 8'd0 : e0_head;
      A_E0CNT:     bus_rdata = cnt0_q;
      A_BULK:      bus_rdata = o_empty ? 8'd0 : o_head;
      default:     bus_rdata = 8'd0;
    endcase
  end

  a_r6_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    dev_off |-> !irq);
  a_r12_gated: assert property (@(posedge clk) disable iff (!rst_n)
    dev_off |-> !(ep0_rx_ready || out_rx_ready || ep0_tx_valid || in_tx_valid));
  a_r8_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_wr && ap_addr == A_CSR0) |=> (cnt0_q <= 8'd1));
  a_r10_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_rd && o_empty) |=> evt_q[EV_UNDER]);
  a_r9_out_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (o_pop && !o_push) |=> (o_cnt == $past(o_cnt) - 1'b1));
  a_r9_in_push: assert property (@(posedge clk) disable iff (!rst_n)
    (i_push && !i_pop) |=> (i_cnt == $past(i_cnt) + 1'b1));
endmodule

// File: tb/test_usbdev_regif.sv
module test_usbdev_regif;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic       rst_n;
  logic [3:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       wr_busy, irq;
  logic [6:0] dev_addr;
  logic       ep0_rx_valid, ep0_rx_ready, ep0_tx_valid, ep0_tx_ready;
  logic [7:0] ep0_rx_data, ep0_tx_data;
  logic       out_rx_valid, out_rx_ready, in_tx_valid, in_tx_ready;
  logic [7:0] out_rx_data, in_tx_data;

  usbdev_regif i_usbdev_regif (.*);

  int    n_chk = 0, n_err = 0;
  string phase = "R1";
  bit    done = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  // reference model state
  bit         pv;
  bit [3:0]   pa;
  bit [7:0]   pd;
  bit [6:0]   m_ctrl, m_addr;
  bit [4:0]   m_evt;
  bit [7:0]   m_omps, m_imps, m_cnt;
  bit [7:0]   m_csr [3];
  logic [7:0] q0[$], qo[$], qi[$];

  always @(posedge clk) begin
    #3;
    if (!rst_n) begin
      pv = 0; pa = 0; pd = 0; m_ctrl = 7'h7D; m_addr = 0; m_evt = 0;
      m_omps = 0; m_imps = 0; m_cnt = 0;
      foreach (m_csr[k]) m_csr[k] = 0;
      q0.delete(); qo.delete(); qi.delete();
    end else begin
      automatic bit dis = m_ctrl[0];
      automatic int s0 = q0.size(), so = qo.size(), si = qi.size();
      automatic bit brd0 = bus_rd && bus_addr == 4'd8;
      automatic bit brdb = bus_rd && bus_addr == 4'd10;
      automatic bit rdy0 = !dis && s0 < 8 && !(pv && pa == 4'd8);
      automatic bit v0 = !dis && s0 > 0 && !brd0;
      automatic bit ordy = !dis && so < 8;
      automatic bit iv = !dis && si > 0;
      automatic bit [4:0] ev = 0, clr = 0;
      automatic bit cc = brd0 && s0 == 1;
      automatic bit acc0 = ep0_rx_valid && rdy0;
      automatic logic [7:0] erd = 0;
      // compare
      chk("wr_busy", wr_busy, pv);
      chk("irq", irq, !dis && |(m_evt & ~m_ctrl[6:2]));
      chk("dev_addr", dev_addr, m_addr);
      chk("ep0_rx_ready", ep0_rx_ready, rdy0);
      chk("ep0_tx_valid", ep0_tx_valid, v0);
      if (v0) chk("ep0_tx_data", ep0_tx_data, q0[0]);
      chk("out_rx_ready", out_rx_ready, ordy);
      chk("in_tx_valid", in_tx_valid, iv);
      if (iv) chk("in_tx_data", in_tx_data, qi[0]);
      if (bus_rd) begin
        case (bus_addr)
          4'd0: erd = {1'b0, m_ctrl};
          4'd1: erd = {3'b0, m_evt};
          4'd2: erd = {1'b0, m_addr};
          4'd3: erd = m_omps;
          4'd4: erd = m_imps;
          4'd5, 4'd6, 4'd7: erd = m_csr[bus_addr - 4'd5];
          4'd8: erd = (s0 == 0) ? 8'd0 : q0[0];
          4'd9: erd = m_cnt;
          4'd10: erd = (so == 0) ? 8'd0 : qo[0];
          default: erd = 0;
        endcase
        chk("bus_rdata", bus_rdata, erd);
      end
      // step
      if (v0 && ep0_tx_ready) void'(q0.pop_front());
      if (brd0) begin
        if (s0 == 0) ev[3] = 1; else void'(q0.pop_front());
      end
      if (acc0) begin q0.push_back(ep0_rx_data); ev[0] = 1; end
      if (brdb) begin
        if (so == 0) ev[3] = 1; else void'(qo.pop_front());
      end
      if (out_rx_valid && ordy) begin qo.push_back(out_rx_data); ev[1] = 1; end
      if (iv && in_tx_ready) begin void'(qi.pop_front()); ev[2] = 1; end
      if (pv) begin
        case (pa)
          4'd0: m_ctrl = pd[6:0];
          4'd1: clr = pd[4:0];
          4'd2: m_addr = pd[6:0];
          4'd3: m_omps = pd;
          4'd4: m_imps = pd;
          4'd5: begin m_csr[0] = pd; cc = 1; end
          4'd6: m_csr[1] = pd;
          4'd7: m_csr[2] = pd;
          4'd8: if (s0 >= 8) ev[4] = 1; else q0.push_back(pd);
          4'd10: if (si >= 8) ev[4] = 1; else qi.push_back(pd);
          default: ;
        endcase
      end
      m_cnt = (cc ? 8'd0 : m_cnt) + {7'd0, acc0};
      m_evt = (m_evt & ~clr) | ev;
      if (bus_wr && !pv) begin pv = 1; pa = bus_addr; pd = bus_wdata; end
      else pv = 0;
    end
  end

  task automatic cyc(bit w, bit r, logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
  endtask
  task automatic idle(int n);
    repeat (n) cyc(0, 0, 4'd0, 8'd0);
  endtask
  task automatic wr(logic [3:0] a, logic [7:0] d);
    cyc(1, 0, a, d); cyc(0, 0, 4'd0, 8'd0);
  endtask
  task automatic rd(logic [3:0] a);
    cyc(0, 1, a, 8'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    ep0_rx_valid = 0; ep0_rx_data = 0; ep0_tx_ready = 0;
    out_rx_valid = 0; out_rx_data = 0; in_tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1"; rd(4'd0); rd(4'd1); rd(4'd2); rd(4'd9); idle(1);
    phase = "R2"; cyc(1, 0, 4'd2, 8'h15); rd(4'd2); rd(4'd2); idle(1);
    phase = "R3"; cyc(1, 0, 4'd3, 8'h40); cyc(1, 0, 4'd3, 8'h11); rd(4'd3); rd(4'd3); idle(1);
    phase = "R4"; wr(4'd2, 8'hFF); rd(4'd2); wr(4'd2, 8'h2A); rd(4'd2);
    phase = "R13"; wr(4'd4, 8'h20); wr(4'd6, 8'hA5); wr(4'd7, 8'h5A); wr(4'd5, 8'h3C);
    rd(4'd4); rd(4'd5); rd(4'd6); rd(4'd7);
    phase = "R6"; wr(4'd0, 8'h00); idle(1);
    phase = "R7";
    for (int i = 0; i < 3; i++) begin
      ep0_rx_valid = 1; ep0_rx_data = 8'h10 + 8'(i); idle(1);
    end
    ep0_rx_valid = 0;
    phase = "R8"; rd(4'd9);
    phase = "R7"; rd(4'd8); rd(4'd8); rd(4'd8);
    phase = "R8"; rd(4'd9);
    phase = "R7"; wr(4'd8, 8'hA1); wr(4'd8, 8'hA2); ep0_tx_ready = 1; idle(3); ep0_tx_ready = 0;
    phase = "R5"; rd(4'd1); wr(4'd1, 8'h02); rd(4'd1); wr(4'd1, 8'h1F); rd(4'd1);
    phase = "R10"; rd(4'd8); rd(4'd10); rd(4'd1); idle(1);
    phase = "R6"; wr(4'd0, 8'h20); idle(1); wr(4'd0, 8'h01); idle(1);
    phase = "R12"; ep0_rx_valid = 1; out_rx_valid = 1; idle(2); ep0_rx_valid = 0; out_rx_valid = 0;
    phase = "R6"; wr(4'd0, 8'h00); idle(1); wr(4'd1, 8'h1F); idle(1);
    phase = "R11";
    for (int i = 0; i < 9; i++) wr(4'd8, 8'h60 + 8'(i));
    rd(4'd1);
    for (int i = 0; i < 9; i++) rd(4'd8);
    rd(4'd9); rd(4'd1); wr(4'd1, 8'h1F);
    phase = "R9";
    out_rx_valid = 1;
    for (int i = 0; i < 10; i++) begin out_rx_data = 8'hC0 + 8'(i); idle(1); end
    out_rx_valid = 0;
    for (int i = 0; i < 8; i++) rd(4'd10);
    for (int i = 0; i < 9; i++) wr(4'd10, 8'h80 + 8'(i));
    rd(4'd1);
    in_tx_ready = 1; idle(3); in_tx_ready = 0; idle(2); in_tx_ready = 1; idle(7); in_tx_ready = 0;
    wr(4'd1, 8'h1F);
    phase = "R12";
    ep0_tx_ready = 1; ep0_rx_valid = 1; ep0_rx_data = 8'h77;
    cyc(1, 0, 4'd8, 8'h99); rd(4'd8); rd(4'd8); rd(4'd8); idle(4);
    ep0_rx_valid = 0; idle(10); ep0_tx_ready = 0;
    phase = "R8";
    ep0_rx_valid = 1; ep0_rx_data = 8'h33; idle(2); ep0_rx_valid = 0;
    rd(4'd9); wr(4'd5, 8'h00); rd(4'd9); rd(4'd5);
    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule